// File: doc/BRIEF.md
# Dual-Slot Header Beat Decoder and Rule Checker

This block sits on the receive side of a wide, one-way header channel. Each clock beat can carry one or two packet headers on a 32-byte bus. A header may start in either of two fixed slots: the lower slot begins at byte 0 and the upper slot at byte 16. Every slot has a 16-bit descriptor alongside the bus. The descriptor holds a traffic-class ID, a channel ID, the header length in 4-byte words, a flag that says whether payload follows on a separate path, and an optional even-parity bit.

The block decodes the descriptor of every slot that is in use. It registers the decoded fields and the raw bus, and presents them one cycle later as two output lanes in arrival order: lane 0 for the lower slot and lane 1 for the upper one. Alongside the decoded output it checks each beat against the channel's rules. Each rule violation sets its own sticky error flag, which only reset clears.

The consumer is the header queue logic downstream. It reads only the lanes whose valid bit is set and watches the four error flags as fatal indications.

Top module: `hdr_rx_unpack`

## Requirements
- R1: A beat presented at clock edge t appears on the outputs after edge t+1, with each emitted lane's fields decoded from its descriptor: channel = bits 7:4, class = bits 3:0, size = bits 12:8, has-data = bit 14. The raw bus is registered unchanged into `out_hdr`.
- R2: Lane 0 carries the lower slot and lane 1 the upper slot. The upper slot is emitted only when the lower slot is valid and the lower header's size is 4 words or less. Nothing is emitted when the lower slot is idle.
- R3: With PARITY_EN=1, a mismatch in an emitted slot sets `err_parity`. The check is that descriptor bit 15 must equal the XOR of descriptor bits 14:0 and every bit of that header's words.
- R4: With PARITY_EN=0, `err_parity` never sets, whatever the descriptor bit 15 holds.
- R5: Descriptor bit 13 is reserved. Setting it changes no decoded field and raises no error, provided parity is kept consistent.
- R6: An upper-slot valid bit without a lower-slot valid bit sets `err_place`, and nothing is emitted for that beat.
- R7: `err_oversize` sets in two cases. The first is when the upper valid bit is high while the lower header is longer than 4 words; lane 1 is then suppressed. The second is when an emitted header would run past the end of the 8-word bus.
- R8: `err_combo` sets when the emitted slots of one beat carry more distinct {channel, class} pairs than MAX_COMBOS (default 1).
- R9: After reset, all outputs are zero. Each error flag stays set until the next reset.
- R10: Parity covers only the words inside a header's stated size. Bytes past its end do not affect the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_SLOTS | Per-slot header-start bits |
| in_hdr | input | 256 | Header bus, byte 0 in bits 7:0 |
| in_info | input | NUM_SLOTS*16 | Per-slot descriptors, slot s at bits 16s+15:16s |
| out_valid | output | NUM_SLOTS | Emitted lanes |
| out_hdr | output | 256 | Registered header bus |
| out_chan | output | NUM_SLOTS*4 | Channel ID per lane |
| out_class | output | NUM_SLOTS*4 | Class ID per lane |
| out_size | output | NUM_SLOTS*5 | Header size in words per lane |
| out_has_data | output | NUM_SLOTS | Payload-follows flag per lane |
| err_parity | output | 1 | Sticky parity error |
| err_place | output | 1 | Sticky slot-placement error |
| err_oversize | output | 1 | Sticky header-length error |
| err_combo | output | 1 | Sticky class/channel-combination error |

## Verification
Two things can happen in the same beat: the two-slot decode with its ordering, and the combination-limit check. Both lanes must appear with correct fields while `err_combo` is judged on the very pair just emitted. The bench provokes this by sending one beat whose two slots differ in channel ID. It then expects lane 0 and lane 1 populated and `err_combo` high in the same output cycle, and it expects no error for two-slot beats that share a key. A second overlap, lane-1 suppression together with the oversize flag, is provoked with a 5-word lower header, and `out_valid` and `err_oversize` are judged together.

// File: rtl/hdr_rx_pkg.sv
package hdr_rx_pkg;

  localparam int INFO_W   = 16;
  localparam int ID_W     = 4;
  localparam int SIZE_W   = 5;
  localparam int WORD_W   = 32;

  // descriptor bit positions (downstream decoders depend on these)
  localparam int PAR_POS   = 15;
  localparam int DATA_POS  = 14;
  localparam int SIZE_LSB  = 8;
  localparam int CHAN_LSB  = 4;
  localparam int CLASS_LSB = 0;

  localparam int NUM_ERR  = 4;
  localparam int E_PARITY = 0;
  localparam int E_PLACE  = 1;
  localparam int E_OVER   = 2;
  localparam int E_COMBO  = 3;

  typedef struct packed {
    logic [ID_W-1:0]   chan;
    logic [ID_W-1:0]   cls;
    logic [SIZE_W-1:0] size;
    logic              has_data;
  } slot_fields_t;

  function automatic slot_fields_t unpack_info(input logic [INFO_W-1:0] d);
    slot_fields_t f;
    f.chan     = d[CHAN_LSB  +: ID_W];
    f.cls      = d[CLASS_LSB +: ID_W];
    f.size     = d[SIZE_LSB  +: SIZE_W];
    f.has_data = d[DATA_POS];
    return f;
  endfunction

endpackage

// File: rtl/hdr_slot_decode.sv
module hdr_slot_decode
  import hdr_rx_pkg::*;
#(
  parameter int BUS_DW    = 8,
  parameter int START_DW  = 0,
  parameter bit PARITY_EN = 1'b1
) (
  input  logic [BUS_DW*WORD_W-1:0] bus,
  input  logic [INFO_W-1:0]        info,
  output slot_fields_t             fields,
  output logic                     par_bad
);

  // XOR of every word that lies inside this header's stated length
  function automatic logic span_xor(input logic [BUS_DW*WORD_W-1:0] b,
                                    input logic [SIZE_W-1:0] sz);
    logic acc;
    int   stop;
    acc  = 1'b0;
    stop = START_DW + int'(sz);
    for (int w = 0; w < BUS_DW; w++) begin
      if (w >= START_DW && w < stop) acc ^= ^b[w*WORD_W +: WORD_W];
    end
    return acc;
  endfunction

  assign fields = unpack_info(info);

  if (PARITY_EN) begin : g_par
    logic expect_par;
    assign expect_par = span_xor(bus, fields.size) ^ (^info[PAR_POS-1:0]);
    assign par_bad    = expect_par != info[PAR_POS];
  end else begin : g_nopar
    assign par_bad = 1'b0;
  end

endmodule

// File: rtl/hdr_beat_rules.sv
module hdr_beat_rules
  import hdr_rx_pkg::*;
#(
  parameter int NUM_SLOTS  = 2,
  parameter int SLOT_DW    = 4,
  parameter int MAX_COMBOS = 1,
  localparam int BUS_DW    = NUM_SLOTS * SLOT_DW,
  localparam int KEY_W     = 2 * ID_W
) (
  input  logic [NUM_SLOTS-1:0]        valid,
  input  logic [NUM_SLOTS*SIZE_W-1:0] sizes,
  input  logic [NUM_SLOTS*KEY_W-1:0]  keys,
  input  logic [NUM_SLOTS-1:0]        par_bad,
  output logic [NUM_SLOTS-1:0]        emit,
  output logic                        ev_parity,
  output logic                        ev_place,
  output logic                        ev_oversize,
  output logic                        ev_combo
);

  always_comb begin
    int cover_end;
    int start;
    emit        = '0;
    ev_place    = 1'b0;
    ev_oversize = 1'b0;
    cover_end   = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      start = s * SLOT_DW;
      if (s > 0 && valid[s] && !valid[0]) ev_place = 1'b1;
      if (valid[s] && valid[0]) begin
        if (start < cover_end) begin
          ev_oversize = 1'b1;
        end else begin
          emit[s]   = 1'b1;
          cover_end = start + int'(sizes[s*SIZE_W +: SIZE_W]);
          if (cover_end > BUS_DW) ev_oversize = 1'b1;
        end
      end
    end
  end

  always_comb begin
    int   distinct;
    logic fresh;
    distinct = 0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      fresh = emit[s];
      for (int k = 0; k < s; k++) begin
        if (emit[k] && keys[k*KEY_W +: KEY_W] == keys[s*KEY_W +: KEY_W]) fresh = 1'b0;
      end
      if (fresh) distinct++;
    end
    ev_combo = distinct > MAX_COMBOS;
  end

  assign ev_parity = |(par_bad & emit);

endmodule

// File: rtl/hdr_err_latch.sv
module hdr_err_latch #(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set,
  output logic [NUM_FLAGS-1:0] flags
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/hdr_rx_unpack.sv
module hdr_rx_unpack
  import hdr_rx_pkg::*;
#(
  parameter int NUM_SLOTS  = 2,
  parameter int SLOT_BYTES = 16,
  parameter int MAX_COMBOS = 1,
  parameter bit PARITY_EN  = 1'b1,
  localparam int SLOT_DW   = SLOT_BYTES / 4,
  localparam int BUS_DW    = NUM_SLOTS * SLOT_DW,
  localparam int BUS_BITS  = BUS_DW * WORD_W,
  localparam int KEY_W     = 2 * ID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        in_valid,
  input  logic [BUS_BITS-1:0]         in_hdr,
  input  logic [NUM_SLOTS*INFO_W-1:0] in_info,
  output logic [NUM_SLOTS-1:0]        out_valid,
  output logic [BUS_BITS-1:0]         out_hdr,
  output logic [NUM_SLOTS*ID_W-1:0]   out_chan,
  output logic [NUM_SLOTS*ID_W-1:0]   out_class,
  output logic [NUM_SLOTS*SIZE_W-1:0] out_size,
  output logic [NUM_SLOTS-1:0]        out_has_data,
  output logic                        err_parity,
  output logic                        err_place,
  output logic                        err_oversize,
  output logic                        err_combo
);

  slot_fields_t [NUM_SLOTS-1:0]  fields;
  logic [NUM_SLOTS-1:0]          par_bad;
  logic [NUM_SLOTS*SIZE_W-1:0]   sizes;
  logic [NUM_SLOTS*KEY_W-1:0]    keys;
  logic [NUM_SLOTS-1:0]          emit;

  // internal events, visible to the checker
  logic ev_parity, ev_place, ev_oversize, ev_combo;
  logic [NUM_ERR-1:0] err_set, err_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    hdr_slot_decode #(
      .BUS_DW   (BUS_DW),
      .START_DW (s * SLOT_DW),
      .PARITY_EN(PARITY_EN)
    ) u_dec (
      .bus    (in_hdr),
      .info   (in_info[s*INFO_W +: INFO_W]),
      .fields (fields[s]),
      .par_bad(par_bad[s])
    );
    assign sizes[s*SIZE_W +: SIZE_W] = fields[s].size;
    assign keys[s*KEY_W +: KEY_W]    = {fields[s].chan, fields[s].cls};
  end

  hdr_beat_rules #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_DW   (SLOT_DW),
    .MAX_COMBOS(MAX_COMBOS)
  ) u_rules (
    .valid      (in_valid),
    .sizes      (sizes),
    .keys       (keys),
    .par_bad    (par_bad),
    .emit       (emit),
    .ev_parity  (ev_parity),
    .ev_place   (ev_place),
    .ev_oversize(ev_oversize),
    .ev_combo   (ev_combo)
  );

  always_comb begin
    err_set           = '0;
    err_set[E_PARITY] = ev_parity;
    err_set[E_PLACE]  = ev_place;
    err_set[E_OVER]   = ev_oversize;
    err_set[E_COMBO]  = ev_combo;
  end

  hdr_err_latch #(.NUM_FLAGS(NUM_ERR)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (err_set),
    .flags(err_q)
  );

  assign err_parity   = err_q[E_PARITY];
  assign err_place    = err_q[E_PLACE];
  assign err_oversize = err_q[E_OVER];
  assign err_combo    = err_q[E_COMBO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= '0;
      out_hdr      <= '0;
      out_chan     <= '0;
      out_class    <= '0;
      out_size     <= '0;
      out_has_data <= '0;
    end else begin
      out_valid <= emit;
      out_hdr   <= in_hdr;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        out_chan[s*ID_W +: ID_W]     <= fields[s].chan;
        out_class[s*ID_W +: ID_W]    <= fields[s].cls;
        out_size[s*SIZE_W +: SIZE_W] <= fields[s].size;
        out_has_data[s]              <= fields[s].has_data;
      end
    end
  end

endmodule

// File: rtl/hdr_rx_checker.sv
module hdr_rx_checker #(
  parameter int SLOT_DW    = 4,
  parameter int MAX_COMBOS = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] in_valid,
  input logic [4:0] lower_size,
  input logic [1:0] out_valid,
  input logic [7:0] out_chan,
  input logic [7:0] out_class,
  input logic       ev_parity,
  input logic       ev_place,
  input logic       ev_oversize,
  input logic       ev_combo,
  input logic       err_parity,
  input logic       err_place,
  input logic       err_oversize,
  input logic       err_combo
);

  AST_LOWER_LANE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[0] |=> out_valid[0]); // R1

  AST_IDLE_EMITS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |=> out_valid == 2'b00); // R2

  AST_UPPER_NEEDS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> out_valid[0]); // R2

  AST_PARITY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_parity |=> err_parity); // R3

  AST_PLACE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[1] && !in_valid[0]) |=> (err_place && out_valid == 2'b00)); // R6

  AST_OVERSIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == 2'b11 && int'(lower_size) > SLOT_DW) |=> (err_oversize && !out_valid[1])); // R7

  AST_OVERSIZE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_oversize |=> err_oversize); // R7

  AST_COMBO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (MAX_COMBOS == 1 && out_valid == 2'b11 &&
     {out_chan[3:0], out_class[3:0]} != {out_chan[7:4], out_class[7:4]}) |-> err_combo); // R8

  AST_COMBO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_combo |=> err_combo); // R8

  AST_PLACE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_place |=> err_place); // R6

  AST_PARITY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity); // R9

  AST_PLACE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_place |=> err_place); // R9

  AST_OVERSIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |=> err_oversize); // R9

  AST_COMBO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    err_combo |=> err_combo); // R9

endmodule

bind hdr_rx_unpack hdr_rx_checker #(
  .SLOT_DW   (SLOT_DW),
  .MAX_COMBOS(MAX_COMBOS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid[1:0]),
  .lower_size  (in_info[12:8]),
  .out_valid   (out_valid[1:0]),
  .out_chan    (out_chan[7:0]),
  .out_class   (out_class[7:0]),
  .ev_parity   (ev_parity),
  .ev_place    (ev_place),
  .ev_oversize (ev_oversize),
  .ev_combo    (ev_combo),
  .err_parity  (err_parity),
  .err_place   (err_place),
  .err_oversize(err_oversize),
  .err_combo   (err_combo)
);

// File: tb/hdr_rx_unpack_tb_top.sv
module hdr_rx_unpack_tb_top;

  typedef struct packed {
    logic [1:0] v;
    logic [3:0] c0; logic [3:0] k0; logic [4:0] s0; logic d0;
    logic [3:0] c1; logic [3:0] k1; logic [4:0] s1; logic d1;
    logic [1:0] ev;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 4'h2, 4'h1, 5'd4, 1'b1, 4'h0, 4'h0, 5'd0, 1'b0, 2'b01},
    '{2'b11, 4'h3, 4'h0, 5'd4, 1'b0, 4'h3, 4'h0, 5'd3, 1'b1, 2'b11},
    '{2'b00, 4'h0, 4'h0, 5'd0, 1'b0, 4'h0, 4'h0, 5'd0, 1'b0, 2'b00},
    '{2'b01, 4'h5, 4'h2, 5'd8, 1'b1, 4'h0, 4'h0, 5'd0, 1'b0, 2'b01},
    '{2'b11, 4'h1, 4'h2, 5'd3, 1'b1, 4'h1, 4'h2, 5'd4, 1'b0, 2'b11},
    '{2'b01, 4'h7, 4'h9, 5'd5, 1'b0, 4'h0, 4'h0, 5'd0, 1'b0, 2'b01},
    '{2'b11, 4'hF, 4'hF, 5'd2, 1'b1, 4'hF, 4'hF, 5'd2, 1'b1, 2'b11}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   in_valid;
  logic [255:0] in_hdr;
  logic [31:0]  in_info;

  logic [1:0]   out_valid, out_has_data;
  logic [255:0] out_hdr;
  logic [7:0]   out_chan, out_class;
  logic [9:0]   out_size;
  logic         err_parity, err_place, err_oversize, err_combo;

  logic [1:0]   np_valid, np_has_data;
  logic [255:0] np_hdr;
  logic [7:0]   np_chan, np_class;
  logic [9:0]   np_size;
  logic         np_err_parity, np_err_place, np_err_oversize, np_err_combo;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  hdr_rx_unpack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_info(in_info),
    .out_valid(out_valid), .out_hdr(out_hdr), .out_chan(out_chan), .out_class(out_class),
    .out_size(out_size), .out_has_data(out_has_data), .err_parity(err_parity),
    .err_place(err_place), .err_oversize(err_oversize), .err_combo(err_combo)
  );

  hdr_rx_unpack #(.PARITY_EN(1'b0)) dut_nopar_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr), .in_info(in_info),
    .out_valid(np_valid), .out_hdr(np_hdr), .out_chan(np_chan), .out_class(np_class),
    .out_size(np_size), .out_has_data(np_has_data), .err_parity(np_err_parity),
    .err_place(np_err_place), .err_oversize(np_err_oversize), .err_combo(np_err_combo)
  );

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] ch, input logic [3:0] cl,
                                     input logic [4:0] sz, input logic hd, input logic rsv);
    logic [15:0] d;
    d = 16'h0;
    d[7:4] = ch; d[3:0] = cl; d[12:8] = sz; d[14] = hd; d[13] = rsv;
    return d;
  endfunction

  // even parity: bit 15 equals the XOR of bits 14:0 and all header bytes in range
  function automatic logic [15:0] seal(input logic [15:0] d, input logic [255:0] h, input int first_byte);
    logic p;
    int   last;
    p    = ^d[14:0];
    last = first_byte + 4 * int'(d[12:8]);
    for (int b = first_byte; b < last && b < 32; b++) p ^= ^h[b*8 +: 8];
    d[15] = p;
    return d;
  endfunction

  function automatic logic [255:0] pattern(input int seed);
    logic [255:0] h;
    for (int b = 0; b < 32; b++) h[b*8 +: 8] = 8'(b * 29 + seed * 7 + 3);
    return h;
  endfunction

  task automatic put(input logic [1:0] v, input logic [15:0] i0, input logic [15:0] i1,
                     input logic [255:0] h);
    in_valid = v;
    in_hdr   = h;
    in_info  = {i1, i0};
  endtask

  // called right after put(): waits one edge, samples on the falling edge
  task automatic expect_out(input string req, input logic [1:0] ev,
                            input logic [15:0] i0, input logic [15:0] i1,
                            input logic [255:0] h, input logic [3:0] eerr);
    logic [15:0] d;
    @(negedge clk);
    check(req, "out_valid", 256'(out_valid), 256'(ev));
    for (int s = 0; s < 2; s++) begin
      d = (s == 0) ? i0 : i1;
      if (ev[s]) begin
        check(req, "chan",     256'(out_chan[s*4 +: 4]),  256'(d[7:4]));
        check(req, "class",    256'(out_class[s*4 +: 4]), 256'(d[3:0]));
        check(req, "size",     256'(out_size[s*5 +: 5]),  256'(d[12:8]));
        check(req, "has_data", 256'(out_has_data[s]),     256'(d[14]));
      end
    end
    check(req, "out_hdr", out_hdr, h);
    check(req, "errors {combo,over,place,par}",
          256'({err_combo, err_oversize, err_place, err_parity}), 256'(eerr));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    put(2'b00, 16'h0, 16'h0, 256'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [255:0] h;
    logic [15:0]  a, b;

    do_reset();
    @(negedge clk);
    // R9: reset state
    check("R9", "reset out_valid", 256'(out_valid), 256'h0);
    check("R9", "reset errors",
          256'({err_combo, err_oversize, err_place, err_parity}), 256'h0);
    check("R9", "reset out_hdr", out_hdr, 256'h0);

    // R1 R2: table of clean beats
    for (int i = 0; i < NVEC; i++) begin
      h = pattern(i);
      a = seal(mk(VECS[i].c0, VECS[i].k0, VECS[i].s0, VECS[i].d0, 1'b0), h, 0);
      b = seal(mk(VECS[i].c1, VECS[i].k1, VECS[i].s1, VECS[i].d1, 1'b0), h, 16);
      put(VECS[i].v, a, b, h);
      expect_out("R1", VECS[i].ev, a, b, h, 4'b0000);
    end

    // R5: reserved bit set, parity kept consistent
    h = pattern(11);
    a = seal(mk(4'h6, 4'h3, 5'd4, 1'b1, 1'b1), h, 0);
    b = seal(mk(4'h6, 4'h3, 5'd2, 1'b0, 1'b1), h, 16);
    put(2'b11, a, b, h);
    expect_out("R5", 2'b11, a, b, h, 4'b0000);

    // R10: corrupt a byte beyond a 3-word header
    h = pattern(12);
    a = seal(mk(4'h2, 4'h2, 5'd3, 1'b0, 1'b0), h, 0);
    h[20*8 +: 8] = h[20*8 +: 8] ^ 8'h01;
    put(2'b01, a, 16'h0, h);
    expect_out("R10", 2'b01, a, 16'h0, h, 4'b0000);

    // R3: corrupt a byte inside the upper header
    h = pattern(13);
    a = seal(mk(4'h1, 4'h1, 5'd4, 1'b0, 1'b0), h, 0);
    b = seal(mk(4'h1, 4'h1, 5'd4, 1'b1, 1'b0), h, 16);
    h[18*8 +: 8] = h[18*8 +: 8] ^ 8'h10;
    put(2'b11, a, b, h);
    expect_out("R3", 2'b11, a, b, h, 4'b0001);
    // R4: the instance without parity stays clean on the same beat
    check("R4", "nopar err_parity", 256'(np_err_parity), 256'h0);
    // R9: flag persists after a clean beat
    h = pattern(14);
    a = seal(mk(4'h1, 4'h1, 5'd4, 1'b0, 1'b0), h, 0);
    put(2'b01, a, 16'h0, h);
    expect_out("R9", 2'b01, a, 16'h0, h, 4'b0001);

    // R4: wrong parity bit on descriptor with parity disabled
    do_reset();
    h = pattern(15);
    a = seal(mk(4'h4, 4'h4, 5'd4, 1'b0, 1'b0), h, 0) ^ 16'h8000;
    put(2'b01, a, 16'h0, h);
    @(negedge clk);
    check("R4", "nopar err_parity", 256'(np_err_parity), 256'h0);
    check("R3", "par err_parity", 256'(err_parity), 256'h1);

    // R6: upper slot alone
    do_reset();
    h = pattern(16);
    b = seal(mk(4'h3, 4'h3, 5'd4, 1'b0, 1'b0), h, 16);
    put(2'b10, 16'h0, b, h);
    expect_out("R6", 2'b00, 16'h0, b, h, 4'b0010);

    // R7: lower header of 5 words with upper valid set
    do_reset();
    h = pattern(17);
    a = seal(mk(4'h3, 4'h3, 5'd5, 1'b0, 1'b0), h, 0);
    b = seal(mk(4'h3, 4'h3, 5'd2, 1'b0, 1'b0), h, 16);
    put(2'b11, a, b, h);
    expect_out("R7", 2'b01, a, b, h, 4'b0100);

    // R7: upper header running past the bus end
    do_reset();
    h = pattern(18);
    a = seal(mk(4'h3, 4'h3, 5'd4, 1'b0, 1'b0), h, 0);
    b = seal(mk(4'h3, 4'h3, 5'd5, 1'b0, 1'b0), h, 16);
    put(2'b11, a, b, h);
    expect_out("R7", 2'b11, a, b, h, 4'b0100);

    // R8: two distinct channel/class pairs in one beat
    do_reset();
    h = pattern(19);
    a = seal(mk(4'h0, 4'h2, 5'd4, 1'b1, 1'b0), h, 0);
    b = seal(mk(4'h1, 4'h2, 5'd4, 1'b1, 1'b0), h, 16);
    put(2'b11, a, b, h);
    expect_out("R8", 2'b11, a, b, h, 4'b1000);
    put(2'b00, 16'h0, 16'h0, h);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule